// File: doc/BRIEF.md
# Key-Locked Flash Control Register Front-End

This block is the register face of an embedded flash controller. Software reaches it through a simple 32-bit register bus with a one-cycle read latency. Every program and erase command is locked out after reset. Two fixed 32-bit values must reach the key register back to back before the control register accepts anything. Any wrong key value leaves the block locked until the next reset.

Once the block is unlocked, software can do three things. It can select halfword programming and then write halfwords through a dedicated array write port. It can erase one page after loading the page address. It can erase the whole array. Each operation holds a busy flag for a configurable wait time and then does its work against an internal block-RAM flash model. At the end it raises an end-of-operation flag. Programming a location that is not blank, or aiming a command at a write-protected page, raises an error flag instead of changing the array.

A second key pair, written to a separate option-key register, opens a small option area of eight halfwords. The low bytes of option halfwords 2 to 5 form the page-group write-protect mask.

Top module: `flk_top`

## Requirements
- R1: After reset, control (offset 0x10) reads 0x00000080 (lock bit 7 set), status (0x0C) reads 0, and write-protect (0x20) reads 0xFFFFFFFF.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register (0x04) unlocks the block, so control bit 7 reads 0.
- R3: Any key-register write that is not the expected next value locks the block until reset. A correct pair written afterwards has no effect, and after a reset the pair unlocks again.
- R4: While locked, writes to control and address (0x14) and array-port writes are ignored, and no operation starts.
- R5: Writing control with bit 7 set relocks the block and clears the mode bits and the option-write-enable bit 9.
- R6: With control bit 0 set, an array-port write to a blank (0xFFFF) location stores the halfword. Status bit 0 (busy) reads 1 from the next cycle, and status bit 5 (end of operation) is set when the operation finishes. Writes to the array port or to control made while busy are ignored.
- R7: Programming a location that does not hold 0xFFFF sets status bit 2 and leaves the location unchanged.
- R8: Control bit 1 together with start bit 6 erases to 0xFFFF every halfword of the page that holds the halfword index in the address register (page = index / PAGE_HW). Other pages are left untouched.
- R9: Control bit 2 together with start bit 6 erases the whole array to 0xFFFF.
- R10: Write-protect bit g covers page group g (group = page / GRP_PAGES), and a 0 means protected. Groups 31 and above all map to bit 31. Programming or page-erasing a protected page, or mass-erasing while any used group is protected, sets status bits 4 and 5 and leaves the array unchanged.
- R11: Status bits 2, 4 and 5 clear only when a 1 is written at their position. Writing 0 there has no effect.
- R12: After unlocking, writing the same key pair to the option-key register (0x08) sets control bit 9. Only with bit 9 set do option program (bit 4, array-port writes with address bit 8 set, option index in bits 2:0) and option erase (bit 5 with start) act. Write-protect bits 8k+7:8k come from the low byte of option halfword 2+k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| arr_wr | input | 1 | Halfword program request |
| arr_waddr | input | HW_W+1 | Halfword index; the top bit selects the option area |
| arr_wdata | input | 16 | Halfword to program |
| arr_raddr | input | HW_W | Array read index |
| arr_rdata | output | 16 | Array read data, one cycle after the index |

## Verification
Register reads return data on the clock edge after the request. The bench drives each request on a falling edge and samples on the following falling edge. Busy is visible to a status read issued right after the launching write. The operation then stays busy for BUSY_CYC wait cycles, plus one cycle per halfword of work (1 for a program, PAGE_HW for a page erase, the whole depth for a mass erase), plus one closing cycle. The bench does not rely on one exact count for every case: it polls the busy bit with a bounded loop and checks the flags and array contents only after busy has dropped. Array reads are checked one edge after the index is applied.

// File: rtl/flk_pkg.sv
package flk_pkg;
  localparam logic [31:0] KEY_A = 32'h4567_0123;
  localparam logic [31:0] KEY_B = 32'hCDEF_89AB;

  localparam logic [7:0] OFF_KEY  = 8'h04;
  localparam logic [7:0] OFF_OKEY = 8'h08;
  localparam logic [7:0] OFF_STS  = 8'h0C;
  localparam logic [7:0] OFF_CTL  = 8'h10;
  localparam logic [7:0] OFF_ADR  = 8'h14;
  localparam logic [7:0] OFF_OPT  = 8'h1C;
  localparam logic [7:0] OFF_WP   = 8'h20;

  localparam int B_PG = 0, B_PER = 1, B_MER = 2, B_OPG = 4, B_OER = 5;
  localparam int B_START = 6, B_LOCK = 7;
  localparam int S_PGERR = 2, S_WPERR = 4, S_EOP = 5;

  localparam int OPT_HW = 8;

  typedef enum logic [2:0] {OP_PROG, OP_PER, OP_MER, OP_OPROG, OP_OER} op_e;
  typedef enum logic [1:0] {G_IDLE, G_HALF, G_OPEN, G_DEAD} gate_e;
  typedef enum logic [1:0] {Q_IDLE, Q_WAIT, Q_EXEC, Q_FIN} seq_e;
endpackage

// File: rtl/flk_keygate.sv
module flk_keygate
  import flk_pkg::*;
#(
  parameter bit LOCKOUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        allow,
  input  logic        key_wr,
  input  logic [31:0] key_val,
  input  logic        relock,
  output logic        open_o
);
  localparam gate_e FAIL_ST = LOCKOUT ? G_DEAD : G_IDLE;

  gate_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= G_IDLE;
    end else if (st == G_DEAD) begin
      st <= G_DEAD;
    end else if (!allow || relock) begin
      st <= G_IDLE;
    end else if (key_wr) begin
      case (st)
        G_IDLE:  st <= (key_val == KEY_A) ? G_HALF : FAIL_ST;
        G_HALF:  st <= (key_val == KEY_B) ? G_OPEN : FAIL_ST;
        default: st <= FAIL_ST;
      endcase
    end
  end

  assign open_o = (st == G_OPEN);

  // R3: a broken sequence is never forgiven before reset
  p_dead_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    st == G_DEAD |=> st == G_DEAD);

  // R2: opening needs the second key right after the first
  p_open_after_second_key_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(open_o) |-> $past(key_wr && key_val == KEY_B && st == G_HALF));
endmodule

// File: rtl/flk_array.sv
module flk_array #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [15:0]   a_wdata,
  output logic [15:0]   a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [15:0]   b_rdata
);
  logic [15:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/flk_seq.sv
module flk_seq
  import flk_pkg::*;
#(
  parameter int NUM_PAGES = 64,
  parameter int PAGE_HW   = 4,
  parameter int GRP_PAGES = 1,
  parameter int BUSY_CYC  = 4,
  localparam int NUM_HW = NUM_PAGES * PAGE_HW,
  localparam int HW_W   = $clog2(NUM_HW),
  localparam int PG_W   = $clog2(PAGE_HW),
  localparam int OW     = $clog2(OPT_HW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  op_e             go_op,
  input  logic [HW_W-1:0] go_addr,
  input  logic [15:0]     go_data,
  input  logic [OW-1:0]   go_oidx,
  input  logic [15:0]     a_rdata,
  output logic            a_we,
  output logic [HW_W-1:0] a_addr,
  output logic [15:0]     a_wdata,
  output logic            busy,
  output logic            eop_set,
  output logic            pgerr_set,
  output logic            wperr_set,
  output logic [31:0]     wp_mask,
  output logic [15:0]     opt0,
  output logic [15:0]     opt1
);
  localparam int NUM_GRP_RAW = (NUM_PAGES + GRP_PAGES - 1) / GRP_PAGES;
  localparam int NUM_GRP     = (NUM_GRP_RAW > 32) ? 32 : NUM_GRP_RAW;
  localparam logic [31:0] GRP_USED = 32'((64'd1 << NUM_GRP) - 64'd1);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  seq_e            st;
  op_e             op_q;
  logic [HW_W-1:0] addr_q, ptr, end_ptr;
  logic [15:0]     data_q;
  logic [OW-1:0]   oidx_q;
  logic            prot_q, err_q, go_prot;
  logic [CNT_W-1:0] cnt;
  logic [15:0]     opt [OPT_HW];

  function automatic logic page_locked(input logic [31:0] m, input logic [HW_W-1:0] a);
    int pg, g;
    pg = int'(a) / PAGE_HW;
    g  = pg / GRP_PAGES;
    if (g > 31) g = 31;
    return !m[g];
  endfunction

  assign wp_mask = {opt[5][7:0], opt[4][7:0], opt[3][7:0], opt[2][7:0]};
  assign opt0 = opt[0];
  assign opt1 = opt[1];

  always_comb begin
    case (go_op)
      OP_PROG, OP_PER: go_prot = page_locked(wp_mask, go_addr);
      OP_MER:          go_prot = |(~wp_mask & GRP_USED);
      default:         go_prot = 1'b0;
    endcase
  end

  wire is_erase = (op_q == OP_PER) || (op_q == OP_MER);
  wire blank    = (a_rdata == 16'hFFFF);

  assign busy      = (st != Q_IDLE);
  assign eop_set   = (st == Q_FIN);
  assign wperr_set = (st == Q_FIN) && prot_q;
  assign pgerr_set = (st == Q_FIN) && err_q;
  assign a_addr    = (st == Q_EXEC && is_erase) ? ptr : addr_q;
  assign a_wdata   = (op_q == OP_PROG) ? data_q : 16'hFFFF;
  assign a_we      = (st == Q_EXEC) && !prot_q &&
                     (is_erase || (op_q == OP_PROG && blank));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= Q_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      oidx_q  <= '0;
      prot_q  <= 1'b0;
      err_q   <= 1'b0;
      cnt     <= '0;
      ptr     <= '0;
      end_ptr <= '0;
    end else begin
      case (st)
        Q_IDLE: if (go) begin
          st     <= Q_WAIT;
          op_q   <= go_op;
          addr_q <= go_addr;
          data_q <= go_data;
          oidx_q <= go_oidx;
          prot_q <= go_prot;
          err_q  <= 1'b0;
          cnt    <= CNT_W'(BUSY_CYC - 1);
          if (go_op == OP_PER) begin
            ptr     <= {go_addr[HW_W-1:PG_W], {PG_W{1'b0}}};
            end_ptr <= {go_addr[HW_W-1:PG_W], {PG_W{1'b1}}};
          end else begin
            ptr     <= '0;
            end_ptr <= '1;
          end
        end
        Q_WAIT: begin
          if (cnt == '0) st <= prot_q ? Q_FIN : Q_EXEC;
          else           cnt <= cnt - 1'b1;
        end
        Q_EXEC: begin
          case (op_q)
            OP_PER, OP_MER: begin
              if (ptr == end_ptr) st <= Q_FIN;
              else                ptr <= ptr + 1'b1;
            end
            OP_PROG: begin
              err_q <= !blank;
              st    <= Q_FIN;
            end
            OP_OPROG: begin
              err_q <= (opt[oidx_q] != 16'hFFFF);
              st    <= Q_FIN;
            end
            default: st <= Q_FIN;
          endcase
        end
        default: st <= Q_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < OPT_HW; i++) begin : g_opt
    always_ff @(posedge clk) begin
      if (rst) begin
        opt[i] <= 16'hFFFF;
      end else if (st == Q_EXEC) begin
        if (op_q == OP_OER)
          opt[i] <= 16'hFFFF;
        else if (op_q == OP_OPROG && oidx_q == OW'(i) && opt[i] == 16'hFFFF)
          opt[i] <= data_q;
      end
    end
  end

  // R6: a launch makes the block busy on the next cycle
  p_busy_after_go_r6: assert property (@(posedge clk) disable iff (rst)
    (go && st == Q_IDLE) |=> busy);

  // R10: a protected operation never writes the array
  p_protected_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    (prot_q && busy) |-> !a_we);

  // R7: a non-blank target is never overwritten
  p_no_overwrite_r7: assert property (@(posedge clk) disable iff (rst)
    (st == Q_EXEC && op_q == OP_PROG && !blank) |-> !a_we);
endmodule

// File: rtl/flk_top.sv
module flk_top
  import flk_pkg::*;
#(
  parameter int NUM_PAGES = 64,
  parameter int PAGE_HW   = 4,
  parameter int GRP_PAGES = 1,
  parameter int BUSY_CYC  = 4,
  localparam int NUM_HW = NUM_PAGES * PAGE_HW,
  localparam int HW_W   = $clog2(NUM_HW),
  localparam int OW     = $clog2(OPT_HW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic            arr_wr,
  input  logic [HW_W:0]   arr_waddr,
  input  logic [15:0]     arr_wdata,
  input  logic [HW_W-1:0] arr_raddr,
  output logic [15:0]     arr_rdata
);
  logic main_open, opt_open, busy;
  logic eop_set, pgerr_set, wperr_set;
  logic eop_q, pgerr_q, wperr_q;
  logic [5:0] mode_q;
  logic [HW_W-1:0] adr_q;
  logic [31:0] wp_mask;
  logic [15:0] opt0, opt1;
  logic a_we;
  logic [HW_W-1:0] a_addr;
  logic [15:0] a_wdata, a_rdata;

  wire wr_any  = bus_sel && bus_wr;
  wire wr_key  = wr_any && bus_addr == OFF_KEY;
  wire wr_okey = wr_any && bus_addr == OFF_OKEY;
  wire wr_sts  = wr_any && bus_addr == OFF_STS;
  wire wr_ctl  = wr_any && bus_addr == OFF_CTL;
  wire wr_adr  = wr_any && bus_addr == OFF_ADR;

  wire relock = main_open && wr_ctl && bus_wdata[B_LOCK];
  wire ctl_ok = wr_ctl && main_open && !busy && !bus_wdata[B_LOCK];

  flk_keygate #(.LOCKOUT(1'b1)) u_main_gate (
    .clk(clk), .rst(rst), .allow(1'b1), .key_wr(wr_key),
    .key_val(bus_wdata), .relock(relock), .open_o(main_open));

  flk_keygate #(.LOCKOUT(1'b0)) u_opt_gate (
    .clk(clk), .rst(rst), .allow(main_open), .key_wr(wr_okey),
    .key_val(bus_wdata), .relock(relock), .open_o(opt_open));

  // launch decode: a register start has priority over an array-port write
  logic go;
  op_e  go_op;
  always_comb begin
    go    = 1'b0;
    go_op = OP_PROG;
    if (ctl_ok && bus_wdata[B_START]) begin
      if (bus_wdata[B_PER] && !bus_wdata[B_MER] && !bus_wdata[B_OER]) begin
        go = 1'b1; go_op = OP_PER;
      end else if (bus_wdata[B_MER] && !bus_wdata[B_PER] && !bus_wdata[B_OER]) begin
        go = 1'b1; go_op = OP_MER;
      end else if (bus_wdata[B_OER] && !bus_wdata[B_PER] && !bus_wdata[B_MER] && opt_open) begin
        go = 1'b1; go_op = OP_OER;
      end
    end else if (arr_wr && main_open && !busy) begin
      if (arr_waddr[HW_W]) begin
        go = mode_q[B_OPG] && opt_open; go_op = OP_OPROG;
      end else begin
        go = mode_q[B_PG]; go_op = OP_PROG;
      end
    end
  end

  wire from_ctl = ctl_ok && bus_wdata[B_START];
  wire [HW_W-1:0] go_addr = from_ctl ? adr_q : arr_waddr[HW_W-1:0];

  flk_seq #(.NUM_PAGES(NUM_PAGES), .PAGE_HW(PAGE_HW), .GRP_PAGES(GRP_PAGES),
            .BUSY_CYC(BUSY_CYC)) u_seq (
    .clk(clk), .rst(rst), .go(go), .go_op(go_op), .go_addr(go_addr),
    .go_data(arr_wdata), .go_oidx(arr_waddr[OW-1:0]),
    .a_rdata(a_rdata), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .busy(busy), .eop_set(eop_set), .pgerr_set(pgerr_set), .wperr_set(wperr_set),
    .wp_mask(wp_mask), .opt0(opt0), .opt1(opt1));

  flk_array #(.DEPTH(NUM_HW)) u_array (
    .clk(clk), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(arr_raddr), .b_rdata(arr_rdata));

  always_ff @(posedge clk) begin
    if (rst || relock || !main_open) mode_q <= '0;
    else if (ctl_ok)                 mode_q <= bus_wdata[5:0] & 6'b110111;
  end

  always_ff @(posedge clk) begin
    if (rst)                             adr_q <= '0;
    else if (wr_adr && main_open && !busy) adr_q <= bus_wdata[HW_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eop_q <= 1'b0; pgerr_q <= 1'b0; wperr_q <= 1'b0;
    end else begin
      eop_q   <= eop_set   || (eop_q   && !(wr_sts && bus_wdata[S_EOP]));
      pgerr_q <= pgerr_set || (pgerr_q && !(wr_sts && bus_wdata[S_PGERR]));
      wperr_q <= wperr_set || (wperr_q && !(wr_sts && bus_wdata[S_WPERR]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFF_STS: bus_rdata <= {26'b0, eop_q, wperr_q, 1'b0, pgerr_q, 1'b0, busy};
        OFF_CTL: bus_rdata <= {22'b0, opt_open, 1'b0, !main_open, 1'b0, mode_q};
        OFF_ADR: bus_rdata <= 32'(adr_q);
        OFF_OPT: bus_rdata <= {16'b0, opt1[7:0], opt0[7:0]};
        OFF_WP:  bus_rdata <= wp_mask;
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R4: no mode survives while locked
  p_mode_clear_locked_r4: assert property (@(posedge clk) disable iff (rst)
    !main_open |-> mode_q == '0);

  // R11: end of operation drops only on a write of 1
  p_eop_w1c_r11: assert property (@(posedge clk) disable iff (rst)
    (eop_q && !(wr_sts && bus_wdata[S_EOP])) |=> eop_q);

  // R10: a protection error always comes with end of operation
  p_wperr_with_eop_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(wperr_q) |-> eop_q);
endmodule

// File: tb/flk_top_tb.sv
module flk_top_tb;
  localparam logic [31:0] K1 = 32'h4567_0123;
  localparam logic [31:0] K2 = 32'hCDEF_89AB;
  localparam logic [7:0] A_KEY = 8'h04, A_OKEY = 8'h08, A_STS = 8'h0C,
                         A_CTL = 8'h10, A_ADR = 8'h14, A_WP = 8'h20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic arr_wr = 1'b0;
  logic [8:0] arr_waddr = '0;
  logic [15:0] arr_wdata = '0, arr_rdata;
  logic [7:0] arr_raddr = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flk_top u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_wr(arr_wr),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .arr_raddr(arr_raddr),
    .arr_rdata(arr_rdata));

  // kind 0 write, 1 read and compare, 2 wait for idle; fields {req, kind, addr, data, exp}
  localparam int NV = 16;
  localparam logic [77:0] TBL [NV] = '{
    {4'd1, 2'd1, A_CTL, 32'h0, 32'h80},        // R1 reset control
    {4'd1, 2'd1, A_STS, 32'h0, 32'h0},         // R1 reset status
    {4'd1, 2'd1, A_WP,  32'h0, 32'hFFFF_FFFF}, // R1 reset protection
    {4'd4, 2'd0, A_CTL, 32'h1, 32'h0},         // R4 write while locked
    {4'd4, 2'd1, A_CTL, 32'h0, 32'h80},        // R4 ignored
    {4'd2, 2'd0, A_KEY, K1, 32'h0},            // R2 first key
    {4'd2, 2'd0, A_KEY, K2, 32'h0},            // R2 second key
    {4'd2, 2'd1, A_CTL, 32'h0, 32'h0},         // R2 unlocked
    {4'd9, 2'd0, A_CTL, 32'h44, 32'h0},        // R9 mass erase start
    {4'd9, 2'd1, A_STS, 32'h0, 32'h1},         // R9 busy at once
    {4'd9, 2'd2, A_STS, 32'h0, 32'h0},         // R9 wait
    {4'd9, 2'd1, A_STS, 32'h0, 32'h20},        // R9 end of operation
    {4'd11, 2'd0, A_STS, 32'h20, 32'h0},       // R11 write 1 clears
    {4'd11, 2'd1, A_STS, 32'h0, 32'h0},        // R11 cleared
    {4'd6, 2'd0, A_CTL, 32'h1, 32'h0},         // R6 select program
    {4'd6, 2'd1, A_CTL, 32'h0, 32'h1}          // R6 mode reads back
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    v = bus_rdata;
  endtask

  task automatic rd_chk(input string rq, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    chk(rq, v, exp);
  endtask

  task automatic arr_write(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    arr_wr = 1'b1; arr_waddr = a; arr_wdata = d;
    @(negedge clk);
    arr_wr = 1'b0;
  endtask

  task automatic arr_chk(input string rq, input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk);
    arr_raddr = a;
    @(negedge clk);
    chk(rq, 32'(arr_rdata), 32'(exp));
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      bus_read(A_STS, v);
      if (!v[0]) break;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      logic [77:0] e;
      e = TBL[i];
      case (e[73:72])
        2'd0: bus_write(e[71:64], e[63:32]);
        2'd1: begin
          bus_read(e[71:64], v);
          chk($sformatf("R%0d", e[77:74]), v, e[31:0]);
        end
        default: wait_idle();
      endcase
    end

    // R6 program a blank halfword
    arr_write(9'd5, 16'h1234);
    rd_chk("R6 busy", A_STS, 32'h1);
    wait_idle();
    rd_chk("R6 eop", A_STS, 32'h20);
    arr_chk("R6 data", 8'd5, 16'h1234);
    bus_write(A_STS, 32'h20);
    arr_write(9'd161, 16'h5555); wait_idle();
    arr_write(9'd9, 16'hABCD);   wait_idle();
    arr_write(9'd120, 16'h0F0F); wait_idle();
    bus_write(A_STS, 32'h34);

    // R7 overwrite refused
    arr_write(9'd5, 16'h0000);
    wait_idle();
    rd_chk("R7 pgerr", A_STS, 32'h24);
    arr_chk("R7 unchanged", 8'd5, 16'h1234);
    // R11 zeros do nothing, ones clear each flag
    bus_write(A_STS, 32'h0);
    rd_chk("R11 zero write", A_STS, 32'h24);
    bus_write(A_STS, 32'h04);
    rd_chk("R11 pgerr clear", A_STS, 32'h20);
    bus_write(A_STS, 32'h20);
    rd_chk("R11 eop clear", A_STS, 32'h0);

    // R8 page erase of page 1 (halfwords 4..7)
    bus_write(A_CTL, 32'h2);
    bus_write(A_ADR, 32'h5);
    rd_chk("R8 addr", A_ADR, 32'h5);
    bus_write(A_CTL, 32'h42);
    wait_idle();
    rd_chk("R8 eop", A_STS, 32'h20);
    arr_chk("R8 erased", 8'd5, 16'hFFFF);
    arr_chk("R8 other page", 8'd9, 16'hABCD);
    bus_write(A_STS, 32'h20);

    // R12 option program without option enable is ignored
    bus_write(A_CTL, 32'h10);
    rd_chk("R12 mode", A_CTL, 32'h10);
    arr_write(9'h105, 16'h007F);
    rd_chk("R12 no start", A_STS, 32'h0);
    rd_chk("R12 wp unchanged", A_WP, 32'hFFFF_FFFF);
    bus_write(A_OKEY, K1);
    bus_write(A_OKEY, K2);
    rd_chk("R12 enable bit", A_CTL, 32'h210);
    arr_write(9'h105, 16'h007F);
    wait_idle();
    rd_chk("R12 eop", A_STS, 32'h20);
    rd_chk("R12 wp from option", A_WP, 32'h7FFF_FFFF);
    bus_write(A_STS, 32'h20);

    // R10 page 40 falls in the shared bit 31
    bus_write(A_CTL, 32'h2);
    bus_write(A_ADR, 32'd160);
    bus_write(A_CTL, 32'h42);
    wait_idle();
    rd_chk("R10 page erase refused", A_STS, 32'h30);
    arr_chk("R10 page kept", 8'd161, 16'h5555);
    bus_write(A_STS, 32'h30);
    bus_write(A_CTL, 32'h44);
    wait_idle();
    rd_chk("R10 mass erase refused", A_STS, 32'h30);
    arr_chk("R10 array kept", 8'd9, 16'hABCD);
    bus_write(A_STS, 32'h30);
    bus_write(A_CTL, 32'h1);
    arr_write(9'd200, 16'h1111);
    wait_idle();
    rd_chk("R10 program refused", A_STS, 32'h30);
    arr_chk("R10 blank kept", 8'd200, 16'hFFFF);
    bus_write(A_STS, 32'h30);
    // R10 page 30 has its own bit and stays open
    bus_write(A_CTL, 32'h2);
    bus_write(A_ADR, 32'd120);
    bus_write(A_CTL, 32'h42);
    wait_idle();
    rd_chk("R10 own bit open", A_STS, 32'h20);
    arr_chk("R10 page 30 erased", 8'd120, 16'hFFFF);
    bus_write(A_STS, 32'h20);

    // R12 option erase
    bus_write(A_CTL, 32'h60);
    wait_idle();
    rd_chk("R12 option erase", A_WP, 32'hFFFF_FFFF);
    bus_write(A_STS, 32'h20);

    // R5 relock
    bus_write(A_CTL, 32'h80);
    rd_chk("R5 relocked", A_CTL, 32'h80);
    // R4 locked writes ignored
    bus_write(A_CTL, 32'h1);
    rd_chk("R4 ctl ignored", A_CTL, 32'h80);
    arr_write(9'd121, 16'h0000);
    rd_chk("R4 no op", A_STS, 32'h0);
    arr_chk("R4 array kept", 8'd121, 16'hFFFF);

    // R3 broken sequence sticks until reset
    bus_write(A_KEY, K1);
    bus_write(A_KEY, 32'h1234_5678);
    bus_write(A_KEY, K1);
    bus_write(A_KEY, K2);
    rd_chk("R3 still locked", A_CTL, 32'h80);
    bus_write(A_ADR, 32'd7);
    rd_chk("R3 addr ignored", A_ADR, 32'd120);
    do_reset();
    bus_write(A_KEY, K1);
    bus_write(A_KEY, K2);
    rd_chk("R3 unlock after reset", A_CTL, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule